// File: doc/BRIEF.md
# Segmented Cache Victim Counter

This block keeps the replacement pointers for a cache split into four segments of 64 entries each. Every segment owns a 6-bit victim pointer, which names the entry to replace next, and a 6-bit lockdown base. Each tag-array access to a segment, read or write, moves that segment's pointer forward by one. When the pointer leaves the last entry it does not return to entry 0. It reloads from the segment's base, so the entries below the base are never chosen and stay locked.

Software, through a coprocessor decoder outside this block, has two ways to set a segment. It can write only the victim, which leaves the base as it was. It can also write the victim and the base together. A tag-array read also copies the pointer value in use for that access into an index register that software can read back. The victim of whichever segment is currently selected is always visible on an output.

Top module: `seg_victim_ctrl`

## Requirements
- R1: After reset every segment's victim and base are 0, and the index register is 0.
- R2: A tag access (`cam_access`=1) with no write command on the selected segment advances that segment's victim by 1 at the next clock edge.
- R3: A tag access while the selected segment's victim is 63 loads the victim from that segment's base instead of going to 64. With base 0, 64 accesses bring the pointer back to its start.
- R4: `wr_victim` alone sets the selected segment's victim to `victim_in` and leaves its base unchanged. `base_in` is ignored.
- R5: `wr_victim_base` sets the selected segment's victim to `victim_in` and its base to `base_in`.
- R6: A tag read (`cam_access`=1, `cam_is_read`=1) loads `index_out` with the selected segment's victim as it was before that access. A tag write (`cam_is_read`=0) or an idle cycle leaves `index_out` unchanged.
- R7: When a write command and a tag access arrive in the same cycle, the written victim value is kept and no increment happens. The index capture of a read still takes the old pointer.
- R8: Segments that are not selected keep their victim and base.
- R9: When `wr_victim` and `wr_victim_base` are both asserted, the combined victim-and-base write takes effect.
- R10: `victim_out` shows the registered victim of the segment that `seg_sel` names, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_sel | input | 2 | Segment addressed by commands, accesses and `victim_out` |
| wr_victim | input | 1 | Write the victim only |
| wr_victim_base | input | 1 | Write the victim and the lockdown base |
| victim_in | input | 6 | Victim value for a write command |
| base_in | input | 6 | Base value for `wr_victim_base` |
| cam_access | input | 1 | Tag-array access strobe for the selected segment |
| cam_is_read | input | 1 | Qualifies `cam_access` as a read, which captures the index |
| victim_out | output | 6 | Current victim of the selected segment |
| index_out | output | 6 | Victim captured by the last tag read |

## Verification
The case that is hardest to reach from the ports is a wrap to a non-zero base that was set earlier, followed by a victim-only write that must keep that base. Nothing shows the base directly, so it can only be seen at the moment of a wrap. The stimulus writes a victim and base pair with the victim at 63, steps the pointer across the wrap, and then writes only the victim back to 63 with a different `base_in` on the bus. A further access then shows whether the old base survived. The same approach exposes the collision cases: a write and an access in one cycle, and both write commands at once.

// File: rtl/seg_victim_pkg.sv
package seg_victim_pkg;

    localparam int unsigned DEF_NUM_SEG = 4;
    localparam int unsigned DEF_PTR_W   = 6;

    typedef enum logic [1:0] {
        CMD_NONE        = 2'd0,
        CMD_VICTIM      = 2'd1,
        CMD_VICTIM_BASE = 2'd2
    } wr_cmd_e;

endpackage

// File: rtl/seg_ptr.sv
module seg_ptr
    import seg_victim_pkg::*;
#(
    parameter int unsigned PTR_W = DEF_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  wr_cmd_e          cmd,
    input  logic [PTR_W-1:0] victim_in,
    input  logic [PTR_W-1:0] base_in,
    input  logic             cam_access,
    output logic [PTR_W-1:0] victim_q
);

    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

    typedef struct packed {
        logic [PTR_W-1:0] victim;
        logic [PTR_W-1:0] base;
    } seg_st_t;

    seg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            unique case (cmd)
                CMD_VICTIM_BASE: begin
                    st_d.victim = victim_in;
                    st_d.base   = base_in;
                end
                CMD_VICTIM: begin
                    st_d.victim = victim_in;
                end
                default: begin
                    if (cam_access) begin
                        if (st_q.victim == PTR_MAX) begin
                            st_d.victim = st_q.base;
                        end else begin
                            st_d.victim = st_q.victim + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_q = st_q.victim;

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_NONE && cam_access && st_q.victim != PTR_MAX)
        |=> st_q.victim == PTR_W'($past(st_q.victim) + 1'b1));

    a_r3_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_NONE && cam_access && st_q.victim == PTR_MAX)
        |=> st_q.victim == $past(st_q.base));

    a_r4_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_VICTIM)
        |=> (st_q.base == $past(st_q.base)) && (st_q.victim == $past(victim_in)));

    a_r5_both_written: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_VICTIM_BASE)
        |=> (st_q.base == $past(base_in)) && (st_q.victim == $past(victim_in)));

    a_r8_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(st_q));

endmodule

// File: rtl/idx_capture.sv
module idx_capture
    import seg_victim_pkg::*;
#(
    parameter int unsigned PTR_W = DEF_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cam_read,
    input  logic [PTR_W-1:0] victim_sel,
    output logic [PTR_W-1:0] idx_q
);

    typedef struct packed {
        logic [PTR_W-1:0] idx;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cam_read) begin
            st_d.idx = victim_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q = st_q.idx;

    a_r6_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
        cam_read |=> idx_q == $past(victim_sel));

    a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !cam_read |=> $stable(idx_q));

endmodule

// File: rtl/seg_victim_ctrl.sv
module seg_victim_ctrl
    import seg_victim_pkg::*;
#(
    parameter int unsigned NUM_SEG = DEF_NUM_SEG,
    parameter int unsigned PTR_W   = DEF_PTR_W,
    localparam int unsigned SEG_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_sel,
    input  logic             wr_victim,
    input  logic             wr_victim_base,
    input  logic [PTR_W-1:0] victim_in,
    input  logic [PTR_W-1:0] base_in,
    input  logic             cam_access,
    input  logic             cam_is_read,
    output logic [PTR_W-1:0] victim_out,
    output logic [PTR_W-1:0] index_out
);

    wr_cmd_e          cmd;
    logic [PTR_W-1:0] seg_victim [NUM_SEG];

    // R9: the combined write takes priority over the victim-only write
    always_comb begin
        if (wr_victim_base) begin
            cmd = CMD_VICTIM_BASE;
        end else if (wr_victim) begin
            cmd = CMD_VICTIM;
        end else begin
            cmd = CMD_NONE;
        end
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_ptr #(.PTR_W(PTR_W)) i_seg_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (seg_sel == SEG_W'(g)),
            .cmd        (cmd),
            .victim_in  (victim_in),
            .base_in    (base_in),
            .cam_access (cam_access),
            .victim_q   (seg_victim[g])
        );
    end

    assign victim_out = seg_victim[seg_sel];

    idx_capture #(.PTR_W(PTR_W)) i_idx_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cam_read   (cam_access && cam_is_read),
        .victim_sel (victim_out),
        .idx_q      (index_out)
    );

    a_r7_write_beats_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_victim || wr_victim_base) && cam_access)
        |=> seg_victim[$past(seg_sel)] == $past(victim_in));

endmodule

// File: tb/test_seg_victim_ctrl.sv
module test_seg_victim_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] seg_sel = '0;
    logic       wr_victim = 1'b0;
    logic       wr_victim_base = 1'b0;
    logic [5:0] victim_in = '0;
    logic [5:0] base_in = '0;
    logic       cam_access = 1'b0;
    logic       cam_is_read = 1'b0;
    logic [5:0] victim_out;
    logic [5:0] index_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_victim_ctrl i_seg_victim_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .seg_sel        (seg_sel),
        .wr_victim      (wr_victim),
        .wr_victim_base (wr_victim_base),
        .victim_in      (victim_in),
        .base_in        (base_in),
        .cam_access     (cam_access),
        .cam_is_read    (cam_is_read),
        .victim_out     (victim_out),
        .index_out      (index_out)
    );

    typedef struct packed {
        logic [1:0] seg;
        logic       wv;
        logic       wvb;
        logic [5:0] vin;
        logic [5:0] bin;
        logic       cam;
        logic       rd;
        logic [5:0] ev;
        logic [5:0] ei;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd1,  6'd0,  8'd2}, // R2 R6 read from 0
        '{2'd0, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd2,  6'd1,  8'd6}, // R6 captures pre-access value
        '{2'd0, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b0, 6'd3,  6'd1,  8'd6}, // R6 tag write keeps index
        '{2'd1, 1'b1, 1'b0, 6'd62, 6'd0,  1'b0, 1'b0, 6'd62, 6'd1,  8'd4}, // R4 victim only
        '{2'd1, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd63, 6'd62, 8'd2}, // R2
        '{2'd1, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd0,  6'd63, 8'd3}, // R3 wrap to base 0
        '{2'd2, 1'b0, 1'b1, 6'd63, 6'd10, 1'b0, 1'b0, 6'd63, 6'd63, 8'd5}, // R5 victim and base
        '{2'd2, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b0, 6'd10, 6'd63, 8'd3}, // R3 wrap to base 10
        '{2'd2, 1'b1, 1'b0, 6'd63, 6'd0,  1'b0, 1'b0, 6'd63, 6'd63, 8'd4}, // R4 base_in ignored
        '{2'd2, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd10, 6'd63, 8'd4}, // R4 base 10 kept
        '{2'd3, 1'b1, 1'b0, 6'd5,  6'd0,  1'b1, 1'b1, 6'd5,  6'd0,  8'd7}, // R7 write beats access
        '{2'd3, 1'b1, 1'b1, 6'd20, 6'd7,  1'b0, 1'b0, 6'd20, 6'd0,  8'd9}, // R9 both commands
        '{2'd3, 1'b1, 1'b0, 6'd63, 6'd33, 1'b0, 1'b0, 6'd63, 6'd0,  8'd4}, // R4
        '{2'd3, 1'b0, 1'b0, 6'd0,  6'd0,  1'b1, 1'b1, 6'd7,  6'd63, 8'd9}, // R9 base 7 set
        '{2'd0, 1'b0, 1'b0, 6'd0,  6'd0,  1'b0, 1'b0, 6'd3,  6'd63, 8'd8}  // R8 seg0 untouched
    };

    task automatic check(input string req, input string what, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_victim = 1'b0;
        wr_victim_base = 1'b0;
        cam_access = 1'b0;
        cam_is_read = 1'b0;
    endtask

    task automatic check_all_segs(input string req, input logic [5:0] e0, input logic [5:0] e1,
                                  input logic [5:0] e2, input logic [5:0] e3);
        logic [5:0] exp_v [4];
        exp_v[0] = e0; exp_v[1] = e1; exp_v[2] = e2; exp_v[3] = e3;
        idle();
        for (int s = 0; s < 4; s++) begin
            seg_sel = 2'(s);
            #1;
            check(req, "victim_out", victim_out, exp_v[s]); // R10 combinational view
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        #7;
        // R1 reset state
        check_all_segs("R1", 6'd0, 6'd0, 6'd0, 6'd0);
        check("R1", "index_out", index_out, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            seg_sel        = VECS[i].seg;
            wr_victim      = VECS[i].wv;
            wr_victim_base = VECS[i].wvb;
            victim_in      = VECS[i].vin;
            base_in        = VECS[i].bin;
            cam_access     = VECS[i].cam;
            cam_is_read    = VECS[i].rd;
            @(posedge clk);
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d victim_out", i), victim_out, VECS[i].ev);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d index_out", i), index_out, VECS[i].ei);
            @(negedge clk);
        end

        // R8 R10: each segment holds its own value
        check_all_segs("R8", 6'd3, 6'd0, 6'd10, 6'd7);

        // R3 full loop on segment 1 (victim 0, base 0): 64 accesses return to 0
        seg_sel = 2'd1;
        cam_access = 1'b1;
        cam_is_read = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(posedge clk);
        end
        #1;
        idle();
        check("R3", "victim_out after 64 steps", victim_out, 6'd0);
        check("R6", "index_out after tag writes", index_out, 6'd63);
        check_all_segs("R8", 6'd3, 6'd0, 6'd10, 6'd7);

        // R1 reset mid-run clears everything, including the bases
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all_segs("R1", 6'd0, 6'd0, 6'd0, 6'd0);
        check("R1", "index_out", index_out, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // base of segment 2 is 0 again: a wrap from 63 returns to 0
        seg_sel = 2'd2;
        wr_victim = 1'b1;
        victim_in = 6'd63;
        @(posedge clk);
        #1;
        wr_victim = 1'b0;
        cam_access = 1'b1;
        cam_is_read = 1'b1;
        @(posedge clk);
        #1;
        idle();
        check("R1", "base cleared by reset", victim_out, 6'd0);
        check("R6", "index_out", index_out, 6'd63);

        finish_run();
    end

endmodule